// File: doc/BRIEF.md
# Tagged Unsigned Adder with Overflow Policies

This block adds two tagged operands as unsigned integers. Each operand is a vector register of `VEC_BYTES` bytes with a tag. The tag gives the element width (1, 2, 4 or 8 bytes) and says whether the operand is a scalar or a full vector. Each element also carries a "not a result" (NaR) flag and a "missing" (None) flag. The same add serves every width and scalarity. A two-bit policy, chosen per operation, sets what happens on overflow: the sum can wrap, it can become a NaR that records the error, it can clamp to the largest value, or it can grow to a double-width exact sum.

Invalid inputs never become arithmetic values. A NaR in either source makes the result a NaR, and its payload is kept so the first failure can be traced. A None source makes the result None. The add has no side effects, so it may be issued speculatively. Any fault is raised later, by whichever consumer has side effects. The result comes out one clock after the operation is accepted, with its own tag. When the widening policy produces more bits than one register holds, the result spans two registers.

Top module: `tagadd_unit`

## Requirements
- R1: `opWidth` selects the element width in bytes: 0→1, 1→2, 2→4, 3→8. Element k occupies bytes k·w to k·w+w−1 of each source, and its NaR and None flags are bit k of the flag vectors.
- R2: Policy 0 (wrap) gives the sum modulo 2^(8w) for each element. For example, 254+3 at one byte gives 1.
- R3: Policy 1 (excepting) turns an overflowing element into a NaR. Its data is `{2'b01, opId}` in the low bits of the element, with all other bits zero. For example, 254+3 at one byte with opId 5 gives a NaR with data 8'h45.
- R4: Policy 2 (saturating) replaces an overflowing element with all ones. For example, 254+3 at one byte gives 255.
- R5: Policy 3 (widening) gives the exact (w·8+1)-bit sum, zero-extended to 2w bytes and placed at byte k·2w of the 2·VEC_BYTES-byte `resData`. For example, 254+3 gives 257 at 2-byte width.
- R6: A scalar operand (`opVector`=0) uses only element 0. Every other element of the result has zero data and clear flags.
- R7: If either source element is a NaR, the result element is a NaR. Its data is source A's element when A is NaR, otherwise source B's element, placed at the element's output slot.
- R8: A None source element with no NaR source gives a None result with zero data. NaR takes precedence over None, and the two output flags are never both set.
- R9: `resValid` follows `opValid` by one clock. Reset clears every output.
- R10: The result tag is as follows. `resWidth` is `opWidth` for policies 0–2 and `opWidth`+1 for policy 3. `resVector` copies `opVector`. `resDouble` is set only for policy 3 when the operand is a vector or the width is 8 bytes.
- R11: Bits of `resData` that no active result element occupies read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| opValid | input | 1 | Operation accepted this cycle |
| opVector | input | 1 | 1 = vector operand, 0 = scalar |
| opWidth | input | 2 | Element width code |
| opPolicy | input | 2 | Overflow policy: 0 wrap, 1 excepting, 2 saturating, 3 widening |
| opId | input | OPID_W | Operation identifier recorded in an overflow NaR |
| aData | input | 8·VEC_BYTES | Source A data |
| aNar | input | VEC_BYTES | Source A NaR flag per element |
| aNone | input | VEC_BYTES | Source A None flag per element |
| bData | input | 8·VEC_BYTES | Source B data |
| bNar | input | VEC_BYTES | Source B NaR flag per element |
| bNone | input | VEC_BYTES | Source B None flag per element |
| resValid | output | 1 | Result valid |
| resVector | output | 1 | Result scalarity tag |
| resWidth | output | 3 | Result width code (0→1 B … 4→16 B) |
| resDouble | output | 1 | Result spans both register halves |
| resData | output | 16·VEC_BYTES | Result data, low half is the first register |
| resNar | output | VEC_BYTES | Result NaR flag per element |
| resNone | output | VEC_BYTES | Result None flag per element |

## Verification
The bench targets the one-byte case 254+3 under all four policies, where a design that mixes up the carry would give 2 or 0 where 1 or 255 is expected. It also drives 8-byte widening. A wrong placement there would drop the carry into the upper register, or shift it into the wrong lane. Lanes that carry NaR and None together, and a NaR arriving only on source B, expose a wrong precedence order or a payload taken from the wrong source. Scalar operations with random upper lanes catch an adder that leaks upper-lane sums or flags into a scalar result.

// File: rtl/tagadd_pkg.sv
package tagadd_pkg;

  typedef enum logic [1:0] {
    POL_WRAP   = 2'd0,
    POL_EXCEPT = 2'd1,
    POL_SAT    = 2'd2,
    POL_WIDE   = 2'd3
  } policy_e;

  localparam logic [1:0] ERR_OVERFLOW = 2'b01;
  localparam int NUM_WC = 4;

  typedef struct packed {
    logic       isVec;
    logic [1:0] wc;
    logic       polWrap;
    logic       polExcept;
    logic       polSat;
    logic       polWide;
    logic       spanBoth;
  } ctrl_strb_t;

endpackage

// File: rtl/tagadd_ctrl.sv
module tagadd_ctrl
  import tagadd_pkg::*;
#(
  parameter int VEC_BYTES = 8
) (
  input  logic                 opVector,
  input  logic [1:0]           opWidth,
  input  logic [1:0]           opPolicy,
  output ctrl_strb_t           strb,
  output logic [VEC_BYTES-1:0] laneEn
);

  localparam logic [1:0] WC_TOP = 2'(NUM_WC - 1);

  always_comb begin
    strb           = '0;
    strb.isVec     = opVector;
    strb.wc        = opWidth;
    unique case (policy_e'(opPolicy))
      POL_WRAP:   strb.polWrap   = 1'b1;
      POL_EXCEPT: strb.polExcept = 1'b1;
      POL_SAT:    strb.polSat    = 1'b1;
      default:    strb.polWide   = 1'b1;
    endcase
    strb.spanBoth = strb.polWide && (opVector || opWidth == WC_TOP);
  end

  always_comb begin
    for (int k = 0; k < VEC_BYTES; k++) begin
      laneEn[k] = opVector ? (k < (VEC_BYTES >> opWidth)) : (k == 0);
    end
  end

endmodule

// File: rtl/tagadd_lanes.sv
module tagadd_lanes
  import tagadd_pkg::*;
#(
  parameter int VEC_BYTES = 8,
  parameter int OPID_W    = 6
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     opValid,
  input  ctrl_strb_t               strb,
  input  logic [VEC_BYTES-1:0]     laneEn,
  input  logic [OPID_W-1:0]        opId,
  input  logic [8*VEC_BYTES-1:0]   aData,
  input  logic [VEC_BYTES-1:0]     aNar,
  input  logic [VEC_BYTES-1:0]     aNone,
  input  logic [8*VEC_BYTES-1:0]   bData,
  input  logic [VEC_BYTES-1:0]     bNar,
  input  logic [VEC_BYTES-1:0]     bNone,
  output logic                     resValid,
  output logic                     resVector,
  output logic [2:0]               resWidth,
  output logic                     resDouble,
  output logic [16*VEC_BYTES-1:0]  resData,
  output logic [VEC_BYTES-1:0]     resNar,
  output logic [VEC_BYTES-1:0]     resNone
);

  localparam int DW = 8 * VEC_BYTES;

  logic [NUM_WC-1:0][2*DW-1:0]    dataG;
  logic [NUM_WC-1:0][VEC_BYTES-1:0] narG;
  logic [NUM_WC-1:0][VEC_BYTES-1:0] noneG;

  // One lane array per width; the tag picks which array feeds the result.
  for (genvar g = 0; g < NUM_WC; g++) begin : gWidth
    localparam int EW = 8 << g;
    localparam int NL = VEC_BYTES >> g;

    logic [EW-1:0]        payload;
    logic [2*DW-1:0]      dG;
    logic [VEC_BYTES-1:0] nG;
    logic [VEC_BYTES-1:0] oG;

    assign payload = EW'({ERR_OVERFLOW, opId});

    always_comb begin
      logic [EW-1:0]   la, lb, v;
      logic [EW:0]     s;
      logic [2*EW-1:0] wv;
      dG = '0;
      nG = '0;
      oG = '0;
      for (int j = 0; j < NL; j++) begin
        la = aData[j*EW +: EW];
        lb = bData[j*EW +: EW];
        s  = {1'b0, la} + {1'b0, lb};
        v  = '0;
        wv = '0;
        if (laneEn[j]) begin
          if (aNar[j]) begin
            nG[j] = 1'b1;
            v     = la;
          end else if (bNar[j]) begin
            nG[j] = 1'b1;
            v     = lb;
          end else if (aNone[j] || bNone[j]) begin
            oG[j] = 1'b1;
          end else if (strb.polWrap) begin
            v = s[EW-1:0];
          end else if (strb.polExcept) begin
            nG[j] = s[EW];
            v     = s[EW] ? payload : s[EW-1:0];
          end else if (strb.polSat) begin
            v = s[EW] ? {EW{1'b1}} : s[EW-1:0];
          end else begin
            v = s[EW-1:0];
          end
          wv = {{EW{1'b0}}, v};
          if (strb.polWide && !(aNar[j] || bNar[j] || aNone[j] || bNone[j])) begin
            wv = {{(EW-1){1'b0}}, s};
          end
        end
        if (strb.polWide) dG[j*2*EW +: 2*EW] = wv;
        else              dG[j*EW +: EW]     = v;
      end
    end

    assign dataG[g] = dG;
    assign narG[g]  = nG;
    assign noneG[g] = oG;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resValid  <= 1'b0;
      resVector <= 1'b0;
      resWidth  <= '0;
      resDouble <= 1'b0;
      resData   <= '0;
      resNar    <= '0;
      resNone   <= '0;
    end else begin
      resValid <= opValid;
      if (opValid) begin
        resVector <= strb.isVec;
        resWidth  <= {1'b0, strb.wc} + {2'b00, strb.polWide};
        resDouble <= strb.spanBoth;
        resData   <= dataG[strb.wc];
        resNar    <= narG[strb.wc];
        resNone   <= noneG[strb.wc];
      end
    end
  end

  // R8: an element is never flagged both NaR and None.
  p_flags_excl_r8: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> ((resNar & resNone) == '0));

  // R7: every active lane with a NaR source yields a NaR result.
  p_nar_prop_r7: assert property (@(posedge clk) disable iff (!rstN)
    opValid |=> (($past((aNar | bNar) & laneEn) & ~resNar) == '0));

  // R8: None sources without NaR yield None.
  p_none_prop_r8: assert property (@(posedge clk) disable iff (!rstN)
    opValid |=> (($past((aNone | bNone) & ~(aNar | bNar) & laneEn) & ~resNone) == '0));

  // R6: a scalar result carries no flags above element 0.
  p_scalar_low_r6: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && !strb.isVec) |=> ((resNar >> 1) == '0 && (resNone >> 1) == '0));

  // R9: result valid trails the operation by one clock.
  p_valid_lag_r9: assert property (@(posedge clk) disable iff (!rstN)
    opValid |=> resValid);

  // R10: widened results carry a width code one above the source.
  p_wide_tag_r10: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && strb.polWide) |=> (resWidth == {1'b0, $past(strb.wc)} + 3'd1));

endmodule

// File: rtl/tagadd_unit.sv
module tagadd_unit
  import tagadd_pkg::*;
#(
  parameter int VEC_BYTES = 8,
  parameter int OPID_W    = 6
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    opValid,
  input  logic                    opVector,
  input  logic [1:0]              opWidth,
  input  logic [1:0]              opPolicy,
  input  logic [OPID_W-1:0]       opId,
  input  logic [8*VEC_BYTES-1:0]  aData,
  input  logic [VEC_BYTES-1:0]    aNar,
  input  logic [VEC_BYTES-1:0]    aNone,
  input  logic [8*VEC_BYTES-1:0]  bData,
  input  logic [VEC_BYTES-1:0]    bNar,
  input  logic [VEC_BYTES-1:0]    bNone,
  output logic                    resValid,
  output logic                    resVector,
  output logic [2:0]              resWidth,
  output logic                    resDouble,
  output logic [16*VEC_BYTES-1:0] resData,
  output logic [VEC_BYTES-1:0]    resNar,
  output logic [VEC_BYTES-1:0]    resNone
);

  ctrl_strb_t           strb;
  logic [VEC_BYTES-1:0] laneEn;

  tagadd_ctrl #(.VEC_BYTES(VEC_BYTES)) u_ctrl (
    .opVector (opVector),
    .opWidth  (opWidth),
    .opPolicy (opPolicy),
    .strb     (strb),
    .laneEn   (laneEn)
  );

  tagadd_lanes #(.VEC_BYTES(VEC_BYTES), .OPID_W(OPID_W)) u_lanes (
    .clk       (clk),
    .rstN      (rstN),
    .opValid   (opValid),
    .strb      (strb),
    .laneEn    (laneEn),
    .opId      (opId),
    .aData     (aData),
    .aNar      (aNar),
    .aNone     (aNone),
    .bData     (bData),
    .bNar      (bNar),
    .bNone     (bNone),
    .resValid  (resValid),
    .resVector (resVector),
    .resWidth  (resWidth),
    .resDouble (resDouble),
    .resData   (resData),
    .resNar    (resNar),
    .resNone   (resNone)
  );

endmodule

// File: tb/tagadd_unit_bench.sv
module tagadd_unit_bench;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         opValid = 1'b0, opVector = 1'b0;
  logic [1:0]   opWidth = '0, opPolicy = '0;
  logic [5:0]   opId = '0;
  logic [63:0]  aData = '0, bData = '0;
  logic [7:0]   aNar = '0, aNone = '0, bNar = '0, bNone = '0;
  logic         resValid, resVector, resDouble;
  logic [2:0]   resWidth;
  logic [127:0] resData;
  logic [7:0]   resNar, resNone;

  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;

  tagadd_unit #(.VEC_BYTES(8), .OPID_W(6)) u_tagadd_unit (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opVector(opVector),
    .opWidth(opWidth), .opPolicy(opPolicy), .opId(opId),
    .aData(aData), .aNar(aNar), .aNone(aNone),
    .bData(bData), .bNar(bNar), .bNone(bNone),
    .resValid(resValid), .resVector(resVector), .resWidth(resWidth),
    .resDouble(resDouble), .resData(resData), .resNar(resNar), .resNone(resNone)
  );

  task automatic model(output logic [127:0] d, output logic [7:0] nr, output logic [7:0] nn);
    int ew, nl;
    logic [127:0] m, x, y, s, v;
    ew = 8 << opWidth;
    nl = opVector ? (8 >> opWidth) : 1;
    m  = (128'h1 << ew) - 128'h1;
    d = '0; nr = '0; nn = '0;
    for (int k = 0; k < nl; k++) begin
      x = ({64'b0, aData} >> (k * ew)) & m;
      y = ({64'b0, bData} >> (k * ew)) & m;
      s = x + y;
      v = '0;
      if (aNar[k]) begin nr[k] = 1'b1; v = x; end
      else if (bNar[k]) begin nr[k] = 1'b1; v = y; end
      else if (aNone[k] || bNone[k]) nn[k] = 1'b1;
      else begin
        case (opPolicy)
          2'd0: v = s & m;
          2'd1: if (s > m) begin nr[k] = 1'b1; v = {120'b0, 2'b01, opId}; end else v = s;
          2'd2: v = (s > m) ? m : s;
          default: v = s;
        endcase
      end
      if (opPolicy == 2'd3) d = d | (v << (k * 2 * ew));
      else                  d = d | (v << (k * ew));
    end
  endtask

  // Drives at a falling edge; result is checked at the next falling edge.
  task automatic applyOp(input string tag);
    logic [127:0] ed;
    logic [7:0]   enr, enn;
    logic [2:0]   ew3;
    logic         edbl;
    model(ed, enr, enn);
    ew3  = {1'b0, opWidth} + ((opPolicy == 2'd3) ? 3'd1 : 3'd0);
    edbl = (opPolicy == 2'd3) && (opVector || opWidth == 2'd3);
    opValid = 1'b1;
    @(negedge clk);
    nChecks++;
    if (!resValid || resVector !== opVector || resWidth !== ew3 || resDouble !== edbl ||
        resData !== ed || resNar !== enr || resNone !== enn) begin
      nFails++;
      $display("FAIL %s: got v=%b vec=%b w=%0d dbl=%b d=%h nar=%b none=%b exp v=1 vec=%b w=%0d dbl=%b d=%h nar=%b none=%b",
               tag, resValid, resVector, resWidth, resDouble, resData, resNar, resNone,
               opVector, ew3, edbl, ed, enr, enn);
    end
  endtask

  task automatic setOp(input logic vec, input logic [1:0] w, input logic [1:0] pol,
                       input logic [63:0] a, input logic [63:0] b);
    opVector = vec; opWidth = w; opPolicy = pol; aData = a; bData = b;
    aNar = '0; bNar = '0; aNone = '0; bNone = '0;
  endtask

  initial begin
    #(8 * 200000);
    nFails++;
    $display("FAIL watchdog: got hung run exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    nChecks++;
    if (resValid !== 1'b0 || resData !== '0 || resNar !== '0 || resNone !== '0) begin
      nFails++;
      $display("FAIL R9 reset: got v=%b d=%h exp v=0 d=0", resValid, resData);
    end
    rstN = 1'b1;
    @(negedge clk);
    opId = 6'd5;

    // 254 + 3 at one byte under each policy
    setOp(1'b0, 2'd0, 2'd0, 64'hFE, 64'h03); applyOp("R2 wrap 254+3");
    setOp(1'b0, 2'd0, 2'd1, 64'hFE, 64'h03); applyOp("R3 except 254+3");
    setOp(1'b0, 2'd0, 2'd2, 64'hFE, 64'h03); applyOp("R4 sat 254+3");
    setOp(1'b0, 2'd0, 2'd3, 64'hFE, 64'h03); applyOp("R5 wide 254+3");
    // scalar ignores garbage in upper elements
    setOp(1'b0, 2'd1, 2'd0, 64'hFFFF_FFFF_FFFF_0001, 64'hFFFF_FFFF_FFFF_0002);
    aNar = 8'hF0; bNone = 8'h0E; applyOp("R6 scalar low only");
    // vector widths and slicing
    setOp(1'b1, 2'd1, 2'd2, 64'hFFFF_8000_0001_7FFF, 64'h0001_8000_0001_0001); applyOp("R1 R4 vec sat 2B");
    setOp(1'b1, 2'd3, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'h2); applyOp("R5 wide 8B spans");
    setOp(1'b1, 2'd0, 2'd3, 64'hFF80_0102_0304_05FF, 64'h0180_FF02_0304_0501); applyOp("R5 R10 wide vec 1B");
    // NaR and None handling
    setOp(1'b1, 2'd0, 2'd0, 64'h1122_3344_5566_7788, 64'h0102_0304_0506_0708);
    aNar = 8'b0000_0001; bNar = 8'b0000_0110; aNone = 8'b0000_0100; bNone = 8'b0001_1000;
    applyOp("R7 R8 precedence");
    setOp(1'b1, 2'd2, 2'd1, 64'hFFFF_FFFF_0000_0010, 64'h0000_0001_0000_0020);
    bNar = 8'b01; applyOp("R3 R7 b payload");
    setOp(1'b1, 2'd2, 2'd3, 64'hDEAD_BEEF_1234_5678, 64'h1);
    bNone = 8'b10; aNar = 8'b01; applyOp("R8 R11 wide flags");
    // idle cycle drops valid
    opValid = 1'b0;
    @(negedge clk);
    nChecks++;
    if (resValid !== 1'b0) begin
      nFails++;
      $display("FAIL R9 idle: got v=%b exp v=0", resValid);
    end

    for (int i = 0; i < 600; i++) begin
      setOp(1'($urandom), 2'($urandom), 2'($urandom),
            {$urandom, $urandom}, {$urandom, $urandom});
      if ($urandom % 4 == 0) begin
        aNar  = 8'($urandom & $urandom & $urandom);
        bNar  = 8'($urandom & $urandom & $urandom);
        aNone = 8'($urandom & $urandom & $urandom);
        bNone = 8'($urandom & $urandom & $urandom);
      end
      opId = 6'($urandom);
      applyOp("R1 R10 R11 random");
    end

    opValid = 1'b0;
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule